// File: doc/BRIEF.md
# I2C SCL divider timing generator

This block derives I2C bus timing from the system clock. A 6-bit divider code chooses a full SCL period and an SDA hold delay. While enabled, the block drives a free-running SCL waveform: low for the first half of each period and high for the second half. It also issues single-cycle strobes at each SCL edge, and an `sda_change` strobe that marks the point after each falling edge where a shifter may present the next data bit.

The code is split into two 3-bit indices. Each index picks a pair of tap constants from a fixed 8-entry table. The period and hold counts follow from a closed formula over those constants. The decoded period is always visible on `period_out` for status readback. A new code is adopted only when a period wraps, or when an `align` request restarts the waveform, so a running SCL never has a truncated phase. Byte shifting, arbitration and register access sit outside this block.

Top module: `scl_divider_timer`

## Requirements
- R1: Code bits [4:2] form index i. Index i selects the pair (base, step) from this list, in index order 0 to 7: (4,1) (4,2) (6,4) (6,8) (14,16) (30,32) (62,64) (126,128).
- R2: Index j is formed from code bit 5 as its MSB, code bit 1 as its middle bit and code bit 0 as its LSB. Index j selects the pair (scl_tap, sda_tap) from this list, in index order 0 to 7: (9,3) (10,3) (12,4) (15,4) (5,1) (6,1) (7,2) (8,2).
- R3: The SCL period in clocks is 2*(base + (scl_tap-1)*step + 2), and `period_out` reports it. Examples: code 0x00 gives 28, code 0x20 gives 20, code 0x15 gives 640, code 0x3F gives 2048 and code 0x1F gives 3840.
- R4: While running, SCL is low for the first half of each period and high for the second half. `scl_fall` pulses for one cycle in the first low cycle, and `scl_rise` pulses for one cycle in the first high cycle.
- R5: `sda_change` pulses once per period, exactly base + (sda_tap-1)*step + 3 cycles after the `scl_fall` cycle. That is 9 cycles for code 0x00, 7 for 0x20, 97 for 0x15, 257 for 0x3F and 513 for 0x1F.
- R6: A change of `div_code` during a period does not alter that period or `period_out`. The new value takes effect from the first cycle of the next period.
- R7: From the cycle after `enable` is seen low, SCL is high and no strobe pulses. From the cycle after `enable` is seen high again, a new period begins with the `scl_fall` pulse.
- R8: An `align` pulse while running restarts the period in the following cycle. The current `div_code` is loaded at that point, and the restart gives an `scl_fall` pulse when SCL was high.
- R9: During and directly after reset, SCL is high, no strobe pulses, and `period_out` shows the code-0 period of 28.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the SCL waveform while high |
| div_code | input | 6 | Frequency-divider code |
| align | input | 1 | Restarts the period and reloads the code |
| scl_out | output | 1 | SCL level |
| scl_rise | output | 1 | One-cycle strobe on the first high cycle |
| scl_fall | output | 1 | One-cycle strobe on the first low cycle |
| sda_change | output | 1 | One-cycle strobe at the end of the SDA hold |
| period_out | output | CNT_W | Decoded SCL period in clocks |

## Verification
A wrong decode shows at once on `period_out`. Within one period it also shows as a misplaced `scl_rise` or `sda_change`, so every code under test is timed edge to edge rather than only read back. A code latch that updates at the wrong moment appears as a period of the old or new length that does not match the expected one, and `period_out` changing in the middle of a period. A counter that fails to clear on disable or align shows within a single cycle, as a missing `scl_fall` or a stray strobe while idle.

// File: rtl/scl_divider_timer.sv
module scl_divider_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [5:0]       div_code,
  input  logic             align,
  output logic             scl_out,
  output logic             scl_rise,
  output logic             scl_fall,
  output logic             sda_change,
  output logic [CNT_W-1:0] period_out
);

  logic [5:0]       code_q;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic             scl_q;
  logic [2:0]       idx_i;
  logic [2:0]       idx_j;
  logic [7:0]       base;
  logic [3:0]       tap_scl;
  logic [3:0]       tap_sda;
  logic [CNT_W-1:0] half_c;
  logic [CNT_W-1:0] hold_c;
  logic [CNT_W-1:0] period_c;
  logic             wrap;

  assign idx_i = code_q[4:2];
  assign idx_j = {code_q[5], code_q[1:0]};

  always_comb begin
    case (idx_i)
      3'd0:    base = 8'd4;
      3'd1:    base = 8'd4;
      3'd2:    base = 8'd6;
      3'd3:    base = 8'd6;
      3'd4:    base = 8'd14;
      3'd5:    base = 8'd30;
      3'd6:    base = 8'd62;
      default: base = 8'd126;
    endcase
  end

  always_comb begin
    case (idx_j)
      3'd0:    begin tap_scl = 4'd9;  tap_sda = 4'd3; end
      3'd1:    begin tap_scl = 4'd10; tap_sda = 4'd3; end
      3'd2:    begin tap_scl = 4'd12; tap_sda = 4'd4; end
      3'd3:    begin tap_scl = 4'd15; tap_sda = 4'd4; end
      3'd4:    begin tap_scl = 4'd5;  tap_sda = 4'd1; end
      3'd5:    begin tap_scl = 4'd6;  tap_sda = 4'd1; end
      3'd6:    begin tap_scl = 4'd7;  tap_sda = 4'd2; end
      default: begin tap_scl = 4'd8;  tap_sda = 4'd2; end
    endcase
  end

  // step = 2**idx_i, so the tap product is a shift
  assign half_c   = CNT_W'(base) + (CNT_W'(tap_scl - 4'd1) << idx_i) + CNT_W'(2);
  assign hold_c   = CNT_W'(base) + (CNT_W'(tap_sda - 4'd1) << idx_i) + CNT_W'(3);
  assign period_c = half_c << 1;
  assign wrap     = (cnt == period_c - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      cnt    <= '0;
      code_q <= '0;
      scl_q  <= 1'b1;
    end else begin
      run   <= enable;
      scl_q <= scl_out;
      if (!run || align || wrap) begin
        cnt    <= '0;
        code_q <= div_code;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign scl_out    = !run || (cnt >= half_c);
  assign scl_fall   = run && scl_q && !scl_out;
  assign scl_rise   = run && !scl_q && scl_out;
  assign sda_change = run && (cnt == hold_c);
  assign period_out = period_c;

endmodule

module scl_divider_timer_props #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             align,
  input logic             scl_out,
  input logic             scl_rise,
  input logic             scl_fall,
  input logic             sda_change,
  input logic [CNT_W-1:0] period_out
);

  assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> (scl_out && !scl_rise && !scl_fall && !sda_change));

  assert_hold_in_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_change |-> !scl_out);

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall, sda_change}));

  assert_code_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !$past(align) && !scl_fall) |-> $stable(period_out));

  assert_period_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (period_out[0] == 1'b0) && (period_out >= CNT_W'(20)) && (period_out <= CNT_W'(3840)));

endmodule

bind scl_divider_timer scl_divider_timer_props #(.CNT_W(CNT_W)) u_props (
  .clk(clk), .rst_n(rst_n), .enable(enable), .align(align),
  .scl_out(scl_out), .scl_rise(scl_rise), .scl_fall(scl_fall),
  .sda_change(sda_change), .period_out(period_out)
);

// File: tb/scl_divider_timer_test.sv
`timescale 1ns/1ps
module scl_divider_timer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [5:0]  div_code;
  logic        align;
  logic        scl_out, scl_rise, scl_fall, sda_change;
  logic [11:0] period_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  scl_divider_timer uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_code(div_code), .align(align),
    .scl_out(scl_out), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_change(sda_change), .period_out(period_out)
  );

  int base_t[8] = '{4, 4, 6, 6, 14, 30, 62, 126};
  int sclt_t[8] = '{9, 10, 12, 15, 5, 6, 7, 8};
  int sdat_t[8] = '{3, 3, 4, 4, 1, 1, 2, 2};

  function automatic int ref_period(input logic [5:0] c);
    int i = int'(c[4:2]);
    int j = int'({c[5], c[1:0]});
    return 2 * (base_t[i] + (sclt_t[j] - 1) * (1 << i) + 2);
  endfunction

  function automatic int ref_hold(input logic [5:0] c);
    int i = int'(c[4:2]);
    int j = int'({c[5], c[1:0]});
    return base_t[i] + (sdat_t[j] - 1) * (1 << i) + 3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_fall(input string req);
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!scl_fall && k < 10000);
    chk(scl_fall, req, int'(scl_fall), 1);
  endtask

  // Starts in an scl_fall cycle, ends in the next scl_fall cycle.
  task automatic measure(input int exp_p, input int exp_h, input string req,
                         input int chg_at, input logic [5:0] chg_code);
    int f_s = -1, f_r = -1, f_f = -1, pbad = 0;
    bit low_ok = 1'b1, high_ok = 1'b1;
    for (int n = 1; n <= exp_p; n++) begin
      @(negedge clk);
      if (sda_change && f_s < 0) f_s = n;
      if (scl_rise && f_r < 0) f_r = n;
      if (scl_fall && f_f < 0) f_f = n;
      if (n < exp_p && int'(period_out) != exp_p) pbad++;
      if (n == 1 && scl_out) low_ok = 1'b0;
      if (n == exp_p / 2 && !scl_out) high_ok = 1'b0;
      if (n == chg_at) div_code = chg_code;
    end
    chk(f_s == exp_h, {req, " R5 sda_change offset"}, f_s, exp_h);
    chk(f_r == exp_p / 2, {req, " R4 scl_rise offset"}, f_r, exp_p / 2);
    chk(f_f == exp_p, {req, " R4 period length"}, f_f, exp_p);
    chk(low_ok && high_ok && !scl_out, {req, " R4 scl level"}, int'(scl_out), 0);
    chk(pbad == 0, {req, " R6 period_out steady"}, pbad, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(scl_out && !scl_rise && !scl_fall && !sda_change, "R9 idle outputs in reset",
        int'({scl_out, scl_rise, scl_fall, sda_change}), 8);
    chk(period_out == 12'd28, "R9 period_out in reset", int'(period_out), 28);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_out && !scl_fall, "R9 idle after reset", int'(scl_out), 1);
  endtask

  task automatic t_code(input logic [5:0] c);
    string tag;
    tag = $sformatf("R1 R2 R3 code %02h", c);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    div_code = c;
    enable   = 1'b1;
    wait_fall(tag);
    chk(int'(period_out) == ref_period(c), {tag, " period_out"}, int'(period_out), ref_period(c));
    measure(ref_period(c), ref_hold(c), tag, -1, c);
  endtask

  task automatic t_change;
    enable = 1'b0;
    repeat (2) @(negedge clk);
    div_code = 6'h00;
    enable   = 1'b1;
    wait_fall("R6 start");
    measure(28, 9, "R6 old code kept", 5, 6'h20);
    chk(period_out == 12'd20, "R6 new code at boundary", int'(period_out), 20);
    measure(20, 7, "R6 new period", -1, 6'h20);
  endtask

  task automatic t_disable;
    int bad = 0;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (!scl_out || scl_rise || scl_fall || sda_change) bad++;
    end
    chk(bad == 0, "R7 idle while disabled", bad, 0);
    enable = 1'b1;
    @(negedge clk);
    chk(scl_fall && !scl_out, "R7 fall on re-enable", int'(scl_fall), 1);
    measure(20, 7, "R7 period after re-enable", -1, 6'h20);
  endtask

  task automatic t_align;
    div_code = 6'h00;
    enable   = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    wait_fall("R8 start");
    repeat (20) @(negedge clk);
    chk(scl_out, "R8 in high phase before align", int'(scl_out), 1);
    align    = 1'b1;
    div_code = 6'h20;
    @(negedge clk);
    align = 1'b0;
    chk(scl_fall && !scl_out, "R8 restart fall", int'(scl_fall), 1);
    chk(period_out == 12'd20, "R8 code loaded on align", int'(period_out), 20);
    measure(20, 7, "R8 period after align", -1, 6'h20);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    enable   = 1'b0;
    div_code = 6'h00;
    align    = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    t_code(6'h00);
    t_code(6'h20);
    t_code(6'h15);
    t_code(6'h3F);
    t_code(6'h1F);
    t_change;
    t_disable;
    t_align;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule